// File: doc/BRIEF.md
# Low-speed USB packet transmitter

This block sends one low-speed USB packet on the D+ and D- lines from a 16 MHz clock. A start strobe comes with a byte count. The count includes the leading sync byte, so it gives the packet length. The block drives the idle J level, turns on the line drivers, and sends the sync byte. It then fetches each payload byte through a simple combinational read port and shifts it out LSB first. Line coding is NRZI with bit stuffing. After the last bit it drives an SE0 end-of-packet, then J for one bit time, then releases both lines to high impedance and pulses a done flag.

A separate strobe sends a handshake packet: the sync byte followed by a single PID byte taken from an input. This path does not touch the read port. A pending device address is applied to the active address output when the bus is released, but only after a data packet, never after a handshake.

Each bit lasts a fixed whole number of clock cycles, with no fractional correction. A low-speed link allows a 1.5 % rate error. The exact bit length is a parameter, so the rate error depends on the value chosen.

Top module: `usb_ls_tx`

## Requirements
- R1: After reset, and at any time while reset is asserted, `oe_o`, `dp_o`, `dm_o` and `done_o` are 0 and `dev_addr_o` is 0.
- R2: In the cycle after a strobe is accepted in idle, the lines show J (`dm_o`=1, `dp_o`=0) with `oe_o`=0. In the next cycle `oe_o` becomes 1 and the first bit starts.
- R3: The packet starts with sync byte 0x80. The remaining bytes are read from `rd_data_i` at `rd_addr_o` = 0, 1, 2, and so on. Every byte is sent LSB first, and every line bit lasts BIT_CYC cycles (11 by default).
- R4: NRZI coding: a 0 bit inverts both lines and a 1 bit leaves them unchanged. While bits are sent, `dp_o` is always the inverse of `dm_o`.
- R5: After six consecutive 1 bits, one extra inversion (a stuffed bit) is inserted and the run count restarts. The run count carries across byte boundaries, including from the sync byte into the first payload byte. A run that completes on the last bit is still stuffed before the end-of-packet.
- R6: The byte count `count_i` is limited to the range 2 to 12. Values below 2 send 2 bytes and values above 12 send 12 bytes.
- R7: After the last line bit, both lines are driven low with `oe_o`=1 for SE0_CYC cycles (22 by default). Then J is driven for J_CYC cycles (11 by default).
- R8: After the J period, `oe_o` and both lines go to 0, and `done_o` is 1 for exactly that one cycle.
- R9: `start_i` and `hs_start_i` are ignored from the accepted strobe until `done_o`. The packet length and timing in progress are not changed.
- R10: `hs_start_i` sends a two-byte packet: sync followed by `hs_pid_i`. When it is asserted together with `start_i`, the handshake packet is sent.
- R11: When a data packet is released, `dev_addr_o` takes the value of `new_addr_i`. After a handshake packet, `dev_addr_o` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 16 MHz clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Strobe that starts a data packet |
| count_i | input | 4 | Byte count, sync byte included |
| hs_start_i | input | 1 | Strobe that starts a handshake packet |
| hs_pid_i | input | 8 | PID byte for the handshake packet |
| rd_addr_o | output | 4 | Index of the payload byte to fetch |
| rd_data_i | input | 8 | Payload byte at `rd_addr_o`, combinational |
| new_addr_i | input | 7 | Pending device address |
| dp_o | output | 1 | D+ level |
| dm_o | output | 1 | D- level |
| oe_o | output | 1 | Line driver enable |
| done_o | output | 1 | One-cycle pulse when the bus is released |
| dev_addr_o | output | 7 | Active device address |

## Verification
All timing is counted from the clock edge that accepts a strobe. J with drivers off appears 0 cycles after that edge. Line bit k covers cycles 1+k·11 to 1+k·11+10, and the bench checks it at the middle of that window. For a packet of N line bits:
- SE0 covers cycles 1+11N to 1+11N+21.
- J covers the next 11 cycles.
- `done_o` is due at cycle 1+11N+33, with a check one cycle before it and one cycle after it.

The bench computes N and the expected level of every bit itself, from the byte list and the stuffing rule. It advances a cycle counter on falling edges and samples only when that counter reaches one of these offsets. The address output is checked once the release cycle has passed.

// File: rtl/usb_ls_tx_pkg.sv
package usb_ls_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PREP,
    ST_SEND,
    ST_SE0,
    ST_DRVJ,
    ST_DONE
  } tx_state_e;

  localparam logic [7:0] SYNC_BYTE = 8'h80;
  localparam int         RUN_MAX   = 6;

endpackage

// File: rtl/usb_ls_tx_timer.sv
module usb_ls_tx_timer #(
  parameter int TW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [TW-1:0] lim,
  output logic          wrap
);

  logic [TW-1:0] cnt_q, cnt_d;

  assign wrap = run && (cnt_q == lim - 1'b1);

  always_comb begin
    if (!run || wrap) cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R3 / R7: the phase counter stays inside the current period length
  a_r3_phase_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q < lim));

endmodule

// File: rtl/usb_ls_tx_nrzi.sv
module usb_ls_tx_nrzi #(
  parameter int RUN_MAX = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic init,
  input  logic step,
  input  logic bit_in,
  output logic line,
  output logic stuff_pend
);

  localparam int OW = $clog2(RUN_MAX + 1);

  logic          line_q, line_d;
  logic [OW-1:0] ones_q, ones_d;
  logic          pend_q, pend_d;

  always_comb begin
    line_d = line_q;
    ones_d = ones_q;
    pend_d = pend_q;
    if (init) begin
      line_d = 1'b1;
      ones_d = '0;
      pend_d = 1'b0;
    end else if (step) begin
      if (pend_q) begin
        line_d = ~line_q;
        ones_d = '0;
        pend_d = 1'b0;
      end else if (bit_in) begin
        ones_d = ones_q + 1'b1;
        pend_d = (ones_q + 1'b1) == OW'(RUN_MAX);
      end else begin
        line_d = ~line_q;
        ones_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= 1'b1;
      ones_q <= '0;
      pend_q <= 1'b0;
    end else begin
      line_q <= line_d;
      ones_q <= ones_d;
      pend_q <= pend_d;
    end
  end

  assign line       = line_q;
  assign stuff_pend = pend_q;

  // R5: a stuffed bit always inverts the line
  a_r5_stuff_toggles: assert property (@(posedge clk) disable iff (!rst_n)
    (step && pend_q && !init) |=> (line_q != $past(line_q)));

endmodule

// File: rtl/usb_ls_tx.sv
module usb_ls_tx
  import usb_ls_tx_pkg::*;
#(
  parameter int MAX_BYTES = 12,
  parameter int MIN_BYTES = 2,
  parameter int BIT_CYC   = 11,
  parameter int SE0_CYC   = 22,
  parameter int J_CYC     = 11,
  parameter int ADDR_BITS = 7,
  parameter int CNT_W     = $clog2(MAX_BYTES + 1),
  parameter int IDX_W     = $clog2(MAX_BYTES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic [CNT_W-1:0]     count_i,
  input  logic                 hs_start_i,
  input  logic [7:0]           hs_pid_i,
  output logic [IDX_W-1:0]     rd_addr_o,
  input  logic [7:0]           rd_data_i,
  input  logic [ADDR_BITS-1:0] new_addr_i,
  output logic                 dp_o,
  output logic                 dm_o,
  output logic                 oe_o,
  output logic                 done_o,
  output logic [ADDR_BITS-1:0] dev_addr_o
);

  localparam int TW = $clog2(BIT_CYC + SE0_CYC + J_CYC + 1);

  tx_state_e            st_q, st_d;
  logic [7:0]           sh_q, sh_d;
  logic [3:0]           bitn_q, bitn_d;
  logic [CNT_W-1:0]     byt_q, byt_d;
  logic [IDX_W-1:0]     idx_q, idx_d;
  logic                 hs_q, hs_d;
  logic [7:0]           pid_q, pid_d;
  logic [ADDR_BITS-1:0] addr_q, addr_d;

  logic             run, wrap, init, step, line, stuff_pend;
  logic [TW-1:0]    lim;
  logic [CNT_W-1:0] cnt_eff;
  logic             need_byte, last_bit;
  logic [7:0]       nb, cur;

  // limit the requested length to the legal range
  always_comb begin
    if (count_i < CNT_W'(MIN_BYTES))      cnt_eff = CNT_W'(MIN_BYTES);
    else if (count_i > CNT_W'(MAX_BYTES)) cnt_eff = CNT_W'(MAX_BYTES);
    else                                  cnt_eff = count_i;
  end

  assign run = (st_q == ST_SEND) || (st_q == ST_SE0) || (st_q == ST_DRVJ);

  always_comb begin
    case (st_q)
      ST_SE0:  lim = TW'(SE0_CYC);
      ST_DRVJ: lim = TW'(J_CYC);
      default: lim = TW'(BIT_CYC);
    endcase
  end

  usb_ls_tx_timer #(.TW(TW)) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (run),
    .lim  (lim),
    .wrap (wrap)
  );

  assign need_byte = (bitn_q == 4'd0);
  assign nb        = hs_q ? pid_q : rd_data_i;
  assign cur       = need_byte ? nb : sh_q;
  assign last_bit  = need_byte && (byt_q == '0);
  assign init      = (st_q == ST_IDLE);

  usb_ls_tx_nrzi #(.RUN_MAX(RUN_MAX)) u_nrzi (
    .clk       (clk),
    .rst_n     (rst_n),
    .init      (init),
    .step      (step),
    .bit_in    (cur[0]),
    .line      (line),
    .stuff_pend(stuff_pend)
  );

  // next-state logic
  always_comb begin
    st_d   = st_q;
    sh_d   = sh_q;
    bitn_d = bitn_q;
    byt_d  = byt_q;
    idx_d  = idx_q;
    hs_d   = hs_q;
    pid_d  = pid_q;
    addr_d = addr_q;
    step   = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (hs_start_i || start_i) begin
          st_d   = ST_PREP;
          sh_d   = SYNC_BYTE;
          bitn_d = 4'd8;
          idx_d  = '0;
          hs_d   = hs_start_i;
          pid_d  = hs_pid_i;
          byt_d  = hs_start_i ? CNT_W'(1) : cnt_eff - 1'b1;
        end
      end
      ST_PREP: begin
        st_d = ST_SEND;
        step = 1'b1;
      end
      ST_SEND: begin
        if (wrap) begin
          if (!stuff_pend && last_bit) st_d = ST_SE0;
          else                         step = 1'b1;
        end
      end
      ST_SE0:  if (wrap) st_d = ST_DRVJ;
      ST_DRVJ: if (wrap) st_d = ST_DONE;
      ST_DONE: begin
        st_d = ST_IDLE;
        if (!hs_q) addr_d = new_addr_i;
      end
      default: st_d = ST_IDLE;
    endcase

    // consume one data bit unless the encoder inserts a stuffed bit
    if (step && !stuff_pend) begin
      if (need_byte) begin
        sh_d   = nb >> 1;
        bitn_d = 4'd7;
        byt_d  = byt_q - 1'b1;
        idx_d  = idx_q + 1'b1;
      end else begin
        sh_d   = sh_q >> 1;
        bitn_d = bitn_q - 4'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      sh_q   <= '0;
      bitn_q <= '0;
      byt_q  <= '0;
      idx_q  <= '0;
      hs_q   <= 1'b0;
      pid_q  <= '0;
      addr_q <= '0;
    end else begin
      st_q   <= st_d;
      sh_q   <= sh_d;
      bitn_q <= bitn_d;
      byt_q  <= byt_d;
      idx_q  <= idx_d;
      hs_q   <= hs_d;
      pid_q  <= pid_d;
      addr_q <= addr_d;
    end
  end

  // line drive
  always_comb begin
    dp_o = 1'b0;
    dm_o = 1'b0;
    oe_o = 1'b0;
    case (st_q)
      ST_PREP: dm_o = 1'b1;
      ST_SEND: begin
        dm_o = line;
        dp_o = ~line;
        oe_o = 1'b1;
      end
      ST_SE0:  oe_o = 1'b1;
      ST_DRVJ: begin
        dm_o = 1'b1;
        oe_o = 1'b1;
      end
      default: ;
    endcase
  end

  assign done_o     = (st_q == ST_DONE);
  assign rd_addr_o  = idx_q;
  assign dev_addr_o = addr_q;

  // R2: drivers only turn on after J was already set up
  a_r2_j_before_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_o) |-> $past(dm_o && !dp_o));

  // R8: done is a single pulse at the release
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r8_release_after_drive: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!oe_o && $past(oe_o)));

  // R9: no new packet starts while one is on the bus
  a_r9_busy_ignores_start: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SEND || st_q == ST_SE0 || st_q == ST_DRVJ) |=> (st_q != ST_PREP));

  // R11: a handshake leaves the active address untouched
  a_r11_hs_keeps_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && hs_q) |=> $stable(dev_addr_o));

endmodule

// File: tb/usb_ls_tx_tb.sv
module usb_ls_tx_tb;

  localparam int CLK_NS = 62;
  localparam int B      = 11;
  localparam int SE0    = 22;
  localparam int JC     = 11;

  // vector: {mode[1:0], count[3:0], a[7:0], step[7:0]}
  // mode 0 = data, 1 = handshake, 2 = both strobes
  localparam int NV = 8;
  localparam logic [21:0] VEC [NV] = '{
    {2'd0, 4'd2,  8'h00, 8'h00},
    {2'd0, 4'd12, 8'hFF, 8'h00},
    {2'd0, 4'd5,  8'h3F, 8'h11},
    {2'd0, 4'd15, 8'hA5, 8'h03},
    {2'd1, 4'd0,  8'hD2, 8'h00},
    {2'd1, 4'd9,  8'h5A, 8'h00},
    {2'd0, 4'd0,  8'h7E, 8'h01},
    {2'd0, 4'd8,  8'hFC, 8'h00}
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic       start_i, hs_start_i;
  logic [3:0] count_i;
  logic [7:0] hs_pid_i;
  logic [3:0] rd_addr_o;
  logic [7:0] rd_data_i;
  logic [6:0] new_addr_i, dev_addr_o;
  logic       dp_o, dm_o, oe_o, done_o;
  logic [7:0] mem [16];

  int n_chk  = 0;
  int n_fail = 0;
  logic [6:0] exp_addr;

  always #(CLK_NS/2) clk = ~clk;
  assign rd_data_i = mem[rd_addr_o];

  usb_ls_tx u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .count_i(count_i),
    .hs_start_i(hs_start_i), .hs_pid_i(hs_pid_i), .rd_addr_o(rd_addr_o),
    .rd_data_i(rd_data_i), .new_addr_i(new_addr_i), .dp_o(dp_o), .dm_o(dm_o),
    .oe_o(oe_o), .done_o(done_o), .dev_addr_o(dev_addr_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got hang expected finish");
    summary();
    $finish;
  end

  task automatic run_pkt(input int mode, input int cnt_in, input logic [7:0] a,
                         input logic [7:0] stp, input bit poke);
    int n, nbits, ones, t, base;
    logic [7:0] bytes [16];
    bit lv [160];
    bit cur;
    n = (mode != 0) ? 2 : (cnt_in < 2 ? 2 : (cnt_in > 12 ? 12 : cnt_in));
    for (int j = 0; j < 16; j++) mem[j] = a + stp * 8'(j);
    bytes[0] = 8'h80;
    for (int i = 1; i < n; i++) bytes[i] = (mode != 0) ? a : mem[i-1];
    // expected NRZI levels of D-, stuffing included (R3 R4 R5)
    cur = 1'b1; ones = 0; nbits = 0;
    for (int i = 0; i < n; i++) begin
      for (int b = 0; b < 8; b++) begin
        if (!bytes[i][b]) cur = ~cur;
        lv[nbits] = cur; nbits++;
        ones = bytes[i][b] ? ones + 1 : 0;
        if (ones == 6) begin
          cur = ~cur; lv[nbits] = cur; nbits++; ones = 0;
        end
      end
    end
    if (mode == 0) exp_addr = new_addr_i;

    start_i    = (mode != 1);
    hs_start_i = (mode != 0);
    hs_pid_i   = a;
    count_i    = 4'(cnt_in);
    @(negedge clk);
    start_i = 1'b0; hs_start_i = 1'b0; t = 0;
    chk(!oe_o && dm_o && !dp_o, "R2 J with drivers off", {oe_o, dm_o, dp_o}, 3'b010);

    for (int k = 0; k < nbits; k++) begin
      while (t < 1 + k*B + B/2) begin @(negedge clk); t++; end
      chk(oe_o && dm_o == lv[k] && dp_o == !lv[k], "R3 R4 R5 line bit",
          {oe_o, dm_o, dp_o}, {1'b1, lv[k], !lv[k]});
      if (poke && k == 2) begin
        // R9: strobes in the middle of a packet must change nothing
        start_i = 1'b1; hs_start_i = 1'b1; count_i = 4'd12;
        @(negedge clk); t++;
        start_i = 1'b0; hs_start_i = 1'b0;
      end
    end
    base = 1 + nbits*B;
    while (t < base + 1) begin @(negedge clk); t++; end
    chk(oe_o && !dm_o && !dp_o, "R7 SE0 start", {oe_o, dm_o, dp_o}, 3'b100);
    while (t < base + SE0 - 1) begin @(negedge clk); t++; end
    chk(oe_o && !dm_o && !dp_o, "R7 SE0 end", {oe_o, dm_o, dp_o}, 3'b100);
    while (t < base + SE0 + JC/2) begin @(negedge clk); t++; end
    chk(oe_o && dm_o && !dp_o, "R7 J drive", {oe_o, dm_o, dp_o}, 3'b110);
    while (t < base + SE0 + JC - 1) begin @(negedge clk); t++; end
    chk(!done_o && oe_o, "R6 R8 R9 no early done", {done_o, oe_o}, 2'b01);
    @(negedge clk); t++;
    chk(done_o && !oe_o && !dm_o && !dp_o, "R6 R8 release",
        {done_o, oe_o, dm_o, dp_o}, 4'b1000);
    @(negedge clk); t++;
    chk(!done_o, "R8 single pulse", done_o, 1'b0);
    chk(dev_addr_o == exp_addr, "R10 R11 device address", dev_addr_o, exp_addr);
  endtask

  initial begin
    rst_n = 1'b0; start_i = 1'b0; hs_start_i = 1'b0; count_i = '0;
    hs_pid_i = '0; new_addr_i = 7'h55; exp_addr = '0;
    for (int j = 0; j < 16; j++) mem[j] = '0;
    repeat (3) @(negedge clk);
    chk(!oe_o && !dp_o && !dm_o && !done_o && dev_addr_o == 0, "R1 reset state",
        {oe_o, dp_o, dm_o, done_o, dev_addr_o}, '0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      new_addr_i = 7'(v*9 + 3);
      run_pkt(int'(VEC[v][21:20]), int'(VEC[v][19:16]), VEC[v][15:8], VEC[v][7:0], 1'b0);
      repeat (2) @(negedge clk);
    end

    // R9: strobes during a packet are ignored
    new_addr_i = 7'h21;
    run_pkt(0, 4, 8'h12, 8'h34, 1'b1);
    // R10: both strobes together send the handshake
    new_addr_i = 7'h3C;
    run_pkt(2, 7, 8'hD2, 8'h00, 1'b0);

    // R1: reset mid-packet releases the bus at once
    new_addr_i = 7'h11;
    start_i = 1'b1; count_i = 4'd6;
    @(negedge clk); start_i = 1'b0;
    repeat (40) @(negedge clk);
    chk(oe_o, "R1 packet running before reset", oe_o, 1'b1);
    rst_n = 1'b0;
    #1;
    chk(!oe_o && !dp_o && !dm_o && !done_o && dev_addr_o == 0, "R1 async reset",
        {oe_o, dp_o, dm_o, done_o, dev_addr_o}, '0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    summary();
    $finish;
  end

endmodule